// File: doc/BRIEF.md
# Programmable Dual-Rail Truth-Table Cell

This block is a single logic element for an array of self-timed cells, written as synchronous logic that samples handshake wires on a clock. Three dual-rail input channels (A, B, C) and one dual-rail output channel (Z) each carry a false rail, a true rail and an enable. A channel holds a token when exactly one of its rails is high. It is empty when both rails are low. An 8-bit configuration word is the truth table of the three-input function.

A small mode field lets the value received on A decide whether B and C are consumed at all, and whether the output token is produced. A channel that is not consumed keeps its enable high and is ignored. A suppressed output still counts as complete, so the inputs are acknowledged without any wait on the receiver. Evaluation starts only when the receiver's enable and the cell's own readiness meet. The usual four-phase return-to-zero sequence then follows.

Top module: `dr_lut_cell`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `z_f` and `z_t` are low, `a_en`, `b_en` and `c_en` are high, and `err` is low.
- R2: A produced token raises exactly one Z rail. `z_t` is raised when `cfg_lut[idx]` is 1, and `z_f` is raised otherwise. Here idx = a + 2*b + 4*c, where each value is the state of that channel's true rail, and an unconsumed channel contributes 0.
- R3: The cell does not evaluate while `z_enable` is low, even when every needed input holds a token. Z stays empty and every input enable stays high.
- R4: After Z becomes valid, all input enables stay high until the receiver lowers `z_enable`. The enables of the consumed channels then fall in the next cycle. A is always consumed.
- R5: Once every consumed channel is empty, Z returns to empty and all enables rise in the same cycle.
- R6: Each of `cfg_b_mode` and `cfg_c_mode` selects when its channel is consumed. 2'b00 and 2'b11 mean always. 2'b01 means only when A is 0. 2'b10 means only when A is 1. An unconsumed channel's enable stays high for the whole token, and its data has no effect on Z.
- R7: When `cfg_z_skip` is 1 and A is 1, no Z rail is raised. The consumed inputs are then acknowledged without waiting for `z_enable` to fall.
- R8: When any input channel has both rails high, `err` is high in the next cycle. No evaluation takes place while that condition lasts.
- R9: The truth table, the mode fields and the skip bit are captured at evaluation. Changes made while a token is in flight do not alter that token's output or acknowledgements.
- R10: When the two rails of A are exchanged at the sender, the output equals the function with A complemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_lut | input | 8 | Truth table, one bit per input combination |
| cfg_z_skip | input | 1 | Suppress output token when A is 1 |
| cfg_b_mode | input | 2 | Consumption mode for channel B |
| cfg_c_mode | input | 2 | Consumption mode for channel C |
| a_f | input | 1 | Channel A false rail |
| a_t | input | 1 | Channel A true rail |
| a_en | output | 1 | Channel A enable (low = acknowledged) |
| b_f | input | 1 | Channel B false rail |
| b_t | input | 1 | Channel B true rail |
| b_en | output | 1 | Channel B enable |
| c_f | input | 1 | Channel C false rail |
| c_t | input | 1 | Channel C true rail |
| c_en | output | 1 | Channel C enable |
| z_f | output | 1 | Output false rail |
| z_t | output | 1 | Output true rail |
| z_enable | input | 1 | Receiver enable for Z |
| err | output | 1 | Both rails of some input high |

## Verification
The hardest case to reach is a mode field that changes while a token is held on Z. The change has to arrive after the cell has committed to the token and before the receiver releases it. The stimulus waits for Z to turn valid and flips the B mode in that same sample. It then checks that B's enable follows the mode that was in force at evaluation. A second hard case is a stalled rendezvous. The bench holds the receiver's enable low while all inputs carry tokens, and confirms that nothing moves until the enable is released.

// File: rtl/dr_cell_pkg.sv
package dr_cell_pkg;
  localparam int CELL_IN = 3;
  localparam int LUT_W   = 1 << CELL_IN;
  localparam int MODE_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    RD_ALWAYS     = 2'b00,
    RD_IF_A0      = 2'b01,
    RD_IF_A1      = 2'b10,
    RD_ALWAYS_ALT = 2'b11
  } rd_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_DRAIN = 2'd2
  } cell_state_t;

  typedef struct packed {
    logic valid;
    logic neutral;
    logic bad;
    logic val;
  } rail_info_t;

  function automatic logic mode_hits(input rd_mode_t m, input logic a);
    case (m)
      RD_IF_A0: return !a;
      RD_IF_A1: return a;
      default:  return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/dr_rail_rx.sv
module dr_rail_rx
  import dr_cell_pkg::*;
(
  input  logic       rail_f,
  input  logic       rail_t,
  output rail_info_t info
);
  always_comb begin
    info.valid   = rail_f ^ rail_t;
    info.neutral = !rail_f && !rail_t;
    info.bad     = rail_f && rail_t;
    info.val     = rail_t;
  end
endmodule

// File: rtl/dr_cond_decode.sv
module dr_cond_decode
  import dr_cell_pkg::*;
(
  input  logic [MODE_W-1:0] b_mode,
  input  logic [MODE_W-1:0] c_mode,
  input  logic              z_skip_en,
  input  logic              a_val,
  output logic              rd_b,
  output logic              rd_c,
  output logic              skip_z
);
  always_comb begin
    rd_b   = mode_hits(rd_mode_t'(b_mode), a_val);
    rd_c   = mode_hits(rd_mode_t'(c_mode), a_val);
    skip_z = z_skip_en && a_val;
  end
endmodule

// File: rtl/dr_cell_ctrl.sv
module dr_cell_ctrl
  import dr_cell_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LUT_W-1:0]             lut,
  input  rail_info_t [CELL_IN-1:0]     ch,
  input  logic                         rd_b,
  input  logic                         rd_c,
  input  logic                         skip_z,
  input  logic                         z_en,
  output logic [CELL_IN-1:0]           en_q,
  output logic                         zf_q,
  output logic                         zt_q,
  output logic                         err_q
);
  cell_state_t        state;
  logic               rb_q, rc_q;
  logic               any_bad;
  logic               ready;
  logic               drained;
  logic [CELL_IN-1:0] idx;

  always_comb begin
    any_bad = 1'b0;
    for (int i = 0; i < CELL_IN; i++) any_bad = any_bad | ch[i].bad;
  end

  always_comb begin
    idx     = {rd_c & ch[2].val, rd_b & ch[1].val, ch[0].val};
    ready   = (state == ST_IDLE) && z_en && !any_bad && ch[0].valid &&
              (!rd_b || ch[1].valid) && (!rd_c || ch[2].valid);
    drained = ch[0].neutral && (!rb_q || ch[1].neutral) && (!rc_q || ch[2].neutral);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      en_q  <= '1;
      zf_q  <= 1'b0;
      zt_q  <= 1'b0;
      rb_q  <= 1'b0;
      rc_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= any_bad;
      case (state)
        ST_IDLE: if (ready) begin
          rb_q <= rd_b;
          rc_q <= rd_c;
          if (skip_z) begin
            en_q  <= {!rd_c, !rd_b, 1'b0};
            state <= ST_DRAIN;
          end else begin
            zt_q  <= lut[idx];
            zf_q  <= !lut[idx];
            state <= ST_HOLD;
          end
        end
        ST_HOLD: if (!z_en) begin
          en_q  <= {!rc_q, !rb_q, 1'b0};
          state <= ST_DRAIN;
        end
        ST_DRAIN: if (drained) begin
          zf_q  <= 1'b0;
          zt_q  <= 1'b0;
          en_q  <= '1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r2_one_rail: assert property (@(posedge clk) disable iff (rst)
    !(zf_q && zt_q));
  a_r3_eval_needs_go: assert property (@(posedge clk) disable iff (rst)
    $rose(zf_q || zt_q) |-> $past(z_en));
  a_r4_ack_after_release: assert property (@(posedge clk) disable iff (rst)
    ($fell(en_q[0]) && (zf_q || zt_q)) |-> !$past(z_en));
  a_r5_rise_when_empty: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q[0]) |-> (!zf_q && !zt_q));
  a_r6_b_ack_with_a: assert property (@(posedge clk) disable iff (rst)
    (!en_q[1] || !en_q[2]) |-> !en_q[0]);
  a_r8_no_eval_on_bad: assert property (@(posedge clk) disable iff (rst)
    $rose(zf_q || zt_q) |-> !err_q);
endmodule

// File: rtl/dr_lut_cell.sv
module dr_lut_cell
  import dr_cell_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [LUT_W-1:0]    cfg_lut,
  input  logic                cfg_z_skip,
  input  logic [MODE_W-1:0]   cfg_b_mode,
  input  logic [MODE_W-1:0]   cfg_c_mode,
  input  logic                a_f,
  input  logic                a_t,
  output logic                a_en,
  input  logic                b_f,
  input  logic                b_t,
  output logic                b_en,
  input  logic                c_f,
  input  logic                c_t,
  output logic                c_en,
  output logic                z_f,
  output logic                z_t,
  input  logic                z_enable,
  output logic                err
);
  logic [CELL_IN-1:0]       rf, rt, en;
  rail_info_t [CELL_IN-1:0] info;
  logic                     rd_b, rd_c, skip_z;

  assign rf = {c_f, b_f, a_f};
  assign rt = {c_t, b_t, a_t};

  for (genvar g = 0; g < CELL_IN; g++) begin : g_rx
    dr_rail_rx u_rx (.rail_f(rf[g]), .rail_t(rt[g]), .info(info[g]));
  end

  dr_cond_decode u_dec (
    .b_mode(cfg_b_mode), .c_mode(cfg_c_mode), .z_skip_en(cfg_z_skip),
    .a_val(info[0].val), .rd_b(rd_b), .rd_c(rd_c), .skip_z(skip_z)
  );

  dr_cell_ctrl u_ctrl (
    .clk(clk), .rst(rst), .lut(cfg_lut), .ch(info),
    .rd_b(rd_b), .rd_c(rd_c), .skip_z(skip_z), .z_en(z_enable),
    .en_q(en), .zf_q(z_f), .zt_q(z_t), .err_q(err)
  );

  assign a_en = en[0];
  assign b_en = en[1];
  assign c_en = en[2];
endmodule

// File: tb/dr_lut_cell_test.sv
module dr_lut_cell_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cfg_lut = 8'h96;
  logic cfg_z_skip = 1'b0;
  logic [1:0] cfg_b_mode = 2'b00, cfg_c_mode = 2'b00;
  logic a_f = 0, a_t = 0, b_f = 0, b_t = 0, c_f = 0, c_t = 0;
  logic z_enable = 1'b1;
  logic a_en, b_en, c_en, z_f, z_t, err;

  int checks = 0, fails = 0;
  bit exp_q[$];
  bit hold = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dr_lut_cell uut (
    .clk(clk), .rst(rst), .cfg_lut(cfg_lut), .cfg_z_skip(cfg_z_skip),
    .cfg_b_mode(cfg_b_mode), .cfg_c_mode(cfg_c_mode),
    .a_f(a_f), .a_t(a_t), .a_en(a_en), .b_f(b_f), .b_t(b_t), .b_en(b_en),
    .c_f(c_f), .c_t(c_t), .c_en(c_en), .z_f(z_f), .z_t(z_t),
    .z_enable(z_enable), .err(err)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit reads(bit [1:0] m, bit a);
    if (m == 2'b01) return !a;
    if (m == 2'b10) return a;
    return 1'b1;
  endfunction

  // Monitor and receiver: compares each Z token with the scoreboard queue.
  initial begin
    forever begin
      @(negedge clk);
      if (rst) z_enable = 1'b1;
      else if (hold) z_enable = 1'b0;
      else if (z_enable && (z_f || z_t)) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2 actual=token expected=none");
        end else begin
          bit e;
          e = exp_q.pop_front();
          if ({z_f, z_t} != {!e, e}) begin
            fails++;
            $display("FAIL R2 actual=%b%b expected=%b%b", z_f, z_t, !e, e);
          end
        end
        z_enable = 1'b0;
      end else if (!z_enable && !z_f && !z_t) z_enable = 1'b1;
    end
  end

  task automatic wait_a_en(bit lvl, string req);
    int n = 0;
    while (a_en != lvl && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(req, a_en, lvl);
  endtask

  task automatic send(bit a, bit b, bit c, bit swap_a, bit stall, bit flip);
    bit ae, rb, rc, sk, e;
    bit [2:0] idx;
    ae = swap_a ? !a : a;
    rb = reads(cfg_b_mode, ae);
    rc = reads(cfg_c_mode, ae);
    sk = cfg_z_skip && ae;
    idx = {rc & c, rb & b, ae};
    e = cfg_lut[idx];
    if (!sk) exp_q.push_back(e);
    if (stall) begin
      hold = 1'b1;
      repeat (2) @(negedge clk);
    end
    if (swap_a) begin a_t = !a; a_f = a; end else begin a_t = a; a_f = !a; end
    b_t = b; b_f = !b; c_t = c; c_f = !c;
    if (stall) begin
      repeat (5) @(negedge clk);
      check("R3 z held empty", {z_f, z_t}, 0);
      check("R3 a_en high", a_en, 1);
      hold = 1'b0;
    end
    if (flip) begin
      int n = 0;
      while (!(z_f || z_t) && n < 100) begin @(negedge clk); n++; end
      cfg_b_mode = rb ? (ae ? 2'b01 : 2'b10) : 2'b00;
    end
    wait_a_en(1'b0, "R4 a acknowledged");
    if (sk) check("R7 z stays empty", {z_f, z_t}, 0);
    check(flip ? "R9 b_en uses captured mode" : "R6 b_en", b_en, !rb);
    check("R6 c_en", c_en, !rc);
    a_f = 0; a_t = 0;
    if (rb) begin b_f = 0; b_t = 0; end
    if (rc) begin c_f = 0; c_t = 0; end
    wait_a_en(1'b1, "R5 enables back");
    check("R5 z empty", {z_f, z_t}, 0);
    check("R5 b_en", b_en, 1);
    check("R5 c_en", c_en, 1);
    b_f = 0; b_t = 0; c_f = 0; c_t = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 z", {z_f, z_t}, 0);
    check("R1 en", {a_en, b_en, c_en}, 3'b111);
    check("R1 err", err, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {a_en, b_en, c_en, z_f, z_t, err}, 6'b111000);

    // R2: xor3 over all combinations, then majority
    for (int i = 0; i < 8; i++) send(i[0], i[1], i[2], 0, 0, 0);
    cfg_lut = 8'hE8;
    for (int i = 0; i < 8; i += 3) send(i[0], i[1], i[2], 0, 0, 0);

    // R10: rail-swapped A
    cfg_lut = 8'h2C;
    send(1, 1, 0, 1, 0, 0);
    send(0, 1, 0, 1, 0, 0);

    // R3: stalled rendezvous
    send(1, 0, 1, 0, 1, 0);

    // R6: conditional consumption of B and C
    cfg_lut = 8'hB4;
    cfg_b_mode = 2'b01;
    send(1, 1, 1, 0, 0, 0);
    send(0, 1, 1, 0, 0, 0);
    cfg_b_mode = 2'b00; cfg_c_mode = 2'b10;
    send(0, 1, 1, 0, 0, 0);
    send(1, 0, 1, 0, 0, 0);
    cfg_c_mode = 2'b11;
    send(0, 0, 1, 0, 0, 0);
    cfg_c_mode = 2'b00;

    // R7: output skip
    cfg_z_skip = 1'b1;
    send(1, 1, 0, 0, 0, 0);
    send(0, 1, 0, 0, 0, 0);
    cfg_z_skip = 1'b0;

    // R9: mode changed while token held
    cfg_b_mode = 2'b00;
    send(1, 1, 0, 0, 0, 1);
    cfg_b_mode = 2'b10;
    send(0, 1, 1, 0, 0, 1);
    cfg_b_mode = 2'b00;

    // R8: both rails high on A
    a_f = 1; a_t = 1; b_t = 1; c_t = 1;
    @(negedge clk);
    check("R8 err raised", err, 1);
    repeat (3) @(negedge clk);
    check("R8 no eval", {a_en, z_f, z_t}, 3'b100);
    a_f = 0; a_t = 0; b_t = 0; c_t = 0;
    repeat (2) @(negedge clk);
    check("R8 err cleared", err, 0);
    send(1, 1, 1, 0, 0, 0);

    repeat (5) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule